// File: doc/BRIEF.md
# Byte-Store Execute and Exception Unit

This unit executes the byte-store instruction in the load/store stage of a 32-bit pipeline. It receives the instruction word, three operand values and the machine status flags. It works out the effective address and puts the low byte of the data operand on the correct lane of a 32-bit write bus, with a one-hot byte enable. When the instruction requests it, the byte order used for lane selection is reversed.

When virtual protected mode is active, two inputs report the outcome of the translation and protection checks: a TLB miss and a zone-protection violation. In that mode either one cancels the write and raises an exception instead. The exception carries a syndrome code and saves and then clears the mode flags. Translation, memory, register file and exception vectoring lie outside the unit. The address bus is twice the data width, so that a concatenated extended address can be carried in full. A parameter selects a one-cycle result or a two-cycle result for the area-optimised build.

Top module: `sbyte_store_unit`

## Requirements
- R1: An issued word is executed only when its top six bits equal 110100 and its reserved bits are all zero. Counting bit 0 as the MSB, the reserved bits are bits 21, 23 and 25 to 31. Any other word gives no write and no exception, and it leaves the syndrome unchanged.
- R2: When the extended flag is clear (big-endian bit 24, which is instr[7]), the write address is the 32-bit wrapped sum of the base and index operands, zero-extended to 64 bits.
- R3: When the extended flag is set, the write address is the 64-bit value with the base operand in the upper half and the index operand in the lower half.
- R4: The write data holds the least significant byte of the data operand, repeated on all four byte lanes.
- R5: The effective byte order is little-endian when the status endianness input (1 = little) differs from the reverse flag (big-endian bit 22, which is instr[9]). For an address offset k (address bits [1:0]), big-endian order enables byte-enable bit 3-k and little-endian order enables bit k. Exactly one bit is set.
- R6: When virtual mode is 1 and a TLB miss is reported, the write is suppressed. Exception-valid pulses, the code becomes 10010 and the store flag becomes 1. The zone flag keeps its previous value.
- R7: When virtual mode is 1, there is no TLB miss and a violation applies, the write is suppressed. Exception-valid pulses, the code becomes 10000, and the store flag and the zone flag both become 1. A TLB miss takes priority over a violation.
- R8: A read-only-zone violation counts in any mode. A no-access violation counts only when the user-mode flag is 1.
- R9: On an exception the outputs give saved-user = user-mode, saved-virtual = virtual mode, and user-mode = virtual mode = 0. Otherwise all four status outputs repeat the status inputs of the same issue cycle.
- R10: When virtual mode is 0, the TLB-miss and violation inputs have no effect and a valid instruction writes.
- R11: After reset every output is 0. The syndrome outputs (code, store flag, zone flag) change only on an exception.
- R12: Results appear 1 cycle after issue when AREA_OPT = 0 and 2 cycles after issue when AREA_OPT = 1. Each valid instruction gives a one-cycle pulse on either the write strobe or exception-valid, never both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Instruction presented this cycle |
| instr | input | 32 | Instruction word (bit 0 = MSB numbering) |
| op_d | input | 32 | Data operand |
| op_a | input | 32 | Base operand |
| op_b | input | 32 | Index operand |
| msr_um_i | input | 1 | User-mode flag |
| msr_vm_i | input | 1 | Virtual-mode flag |
| msr_ums_i | input | 1 | Saved user-mode flag |
| msr_vms_i | input | 1 | Saved virtual-mode flag |
| msr_le_i | input | 1 | Endianness, 1 = little |
| tlb_miss_i | input | 1 | No translation found |
| prot_noacc_i | input | 1 | No-access zone hit |
| prot_ro_i | input | 1 | Read-only zone hit |
| wr_en_o | output | 1 | Write strobe |
| wr_addr_o | output | 64 | Write address |
| wr_data_o | output | 32 | Write data, byte replicated |
| wr_be_o | output | 4 | One-hot byte enable |
| exc_valid_o | output | 1 | Exception raised |
| esr_ec_o | output | 5 | Syndrome code |
| esr_s_o | output | 1 | Syndrome store flag |
| esr_diz_o | output | 1 | Syndrome zone flag |
| msr_um_o | output | 1 | Next user-mode flag |
| msr_vm_o | output | 1 | Next virtual-mode flag |
| msr_ums_o | output | 1 | Next saved user-mode flag |
| msr_vms_o | output | 1 | Next saved virtual-mode flag |

## Verification
A TLB miss and a protection violation can be reported in the same cycle, and the unit then has to choose a single exception code. The same choice arises when a violation arrives while virtual mode is off, or when a no-access hit arrives in supervisor mode. The bench provokes these overlaps with directed cases and with random stimulus that drives all three condition inputs, the mode flags and the reverse/extended bits independently. A bench model predicts the code, the zone flag and the status outputs, and checks that exactly one of write strobe and exception-valid pulses, in both latency builds.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
    localparam int DW   = 32;
    localparam int AW   = 2 * DW;
    localparam int NBE  = DW / 8;
    localparam int OFFW = $clog2(NBE);
    localparam int ECW  = 5;

    localparam logic [5:0]     OPC_SB   = 6'b110100;
    localparam logic [ECW-1:0] EC_TLB   = 5'b10010;
    localparam logic [ECW-1:0] EC_DSTOR = 5'b10000;

    // big-endian bit n maps to vector index DW-1-n
    localparam int IDX_REV = DW - 1 - 22;
    localparam int IDX_EXT = DW - 1 - 24;
    localparam logic [DW-1:0] RSV_MASK =
        ((DW'(1) << (DW - 21)) - DW'(1)) & ~(DW'(1) << IDX_REV) & ~(DW'(1) << IDX_EXT);

    typedef struct packed {
        logic            wr_en;
        logic [AW-1:0]   addr;
        logic [DW-1:0]   data;
        logic [NBE-1:0]  be;
        logic            exc_valid;
        logic [ECW-1:0]  ec;
        logic            s;
        logic            diz;
        logic            um;
        logic            vm;
        logic            ums;
        logic            vms;
    } stage_t;
endpackage

// File: rtl/sbs_decode.sv
module sbs_decode
    import sbs_pkg::*;
(
    input  logic [DW-1:0]   instr,
    input  logic [DW-1:0]   op_a,
    input  logic [DW-1:0]   op_b,
    output logic            hit,
    output logic            rev,
    output logic [AW-1:0]   addr,
    output logic [OFFW-1:0] off
);
    logic [DW-1:0] sum;
    logic          ext;

    assign sum  = op_a + op_b;
    assign ext  = instr[IDX_EXT];
    assign rev  = instr[IDX_REV];
    assign hit  = (instr[DW-1 -: 6] == OPC_SB) && ((instr & RSV_MASK) == '0);
    assign addr = ext ? {op_a, op_b} : {{DW{1'b0}}, sum};
    assign off  = addr[OFFW-1:0];
endmodule

// File: rtl/sbs_lane.sv
module sbs_lane
    import sbs_pkg::*;
(
    input  logic [DW-1:0]   din,
    input  logic [OFFW-1:0] off,
    input  logic            little,
    output logic [DW-1:0]   data,
    output logic [NBE-1:0]  be
);
    logic [OFFW-1:0] lane;

    assign lane = little ? off : (OFFW'(NBE - 1) - off);

    for (genvar g = 0; g < NBE; g++) begin : g_lane
        assign data[g*8 +: 8] = din[7:0];
        assign be[g]          = (lane == OFFW'(g));
    end
endmodule

// File: rtl/sbs_excp.sv
module sbs_excp
    import sbs_pkg::*;
(
    input  logic           vm,
    input  logic           um,
    input  logic           miss,
    input  logic           noacc,
    input  logic           ro,
    output logic           exc,
    output logic [ECW-1:0] ec,
    output logic           diz_set
);
    logic tlb_hit;
    logic prot_hit;

    assign tlb_hit  = vm & miss;
    assign prot_hit = vm & ~miss & (ro | (noacc & um));
    assign exc      = tlb_hit | prot_hit;
    assign ec       = tlb_hit ? EC_TLB : EC_DSTOR;
    assign diz_set  = prot_hit;
endmodule

// File: rtl/sbyte_store_unit.sv
module sbyte_store_unit
    import sbs_pkg::*;
#(
    parameter bit AREA_OPT = 1'b0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           issue_valid,
    input  logic [31:0]    instr,
    input  logic [31:0]    op_d,
    input  logic [31:0]    op_a,
    input  logic [31:0]    op_b,
    input  logic           msr_um_i,
    input  logic           msr_vm_i,
    input  logic           msr_ums_i,
    input  logic           msr_vms_i,
    input  logic           msr_le_i,
    input  logic           tlb_miss_i,
    input  logic           prot_noacc_i,
    input  logic           prot_ro_i,
    output logic           wr_en_o,
    output logic [63:0]    wr_addr_o,
    output logic [31:0]    wr_data_o,
    output logic [3:0]     wr_be_o,
    output logic           exc_valid_o,
    output logic [4:0]     esr_ec_o,
    output logic           esr_s_o,
    output logic           esr_diz_o,
    output logic           msr_um_o,
    output logic           msr_vm_o,
    output logic           msr_ums_o,
    output logic           msr_vms_o
);
    logic            dec_hit;
    logic            dec_rev;
    logic [AW-1:0]   dec_addr;
    logic [OFFW-1:0] dec_off;
    logic [DW-1:0]   lane_data;
    logic [NBE-1:0]  lane_be;
    logic            x_exc;
    logic [ECW-1:0]  x_ec;
    logic            x_diz;

    stage_t st_d;
    stage_t st_q;
    stage_t out_s;

    sbs_decode u_decode (
        .instr (instr),
        .op_a  (op_a),
        .op_b  (op_b),
        .hit   (dec_hit),
        .rev   (dec_rev),
        .addr  (dec_addr),
        .off   (dec_off)
    );

    sbs_lane u_lane (
        .din    (op_d),
        .off    (dec_off),
        .little (msr_le_i ^ dec_rev),
        .data   (lane_data),
        .be     (lane_be)
    );

    sbs_excp u_excp (
        .vm      (msr_vm_i),
        .um      (msr_um_i),
        .miss    (tlb_miss_i),
        .noacc   (prot_noacc_i),
        .ro      (prot_ro_i),
        .exc     (x_exc),
        .ec      (x_ec),
        .diz_set (x_diz)
    );

    always_comb begin
        st_d     = '0;
        st_d.ec  = st_q.ec;
        st_d.s   = st_q.s;
        st_d.diz = st_q.diz;
        st_d.um  = msr_um_i;
        st_d.vm  = msr_vm_i;
        st_d.ums = msr_ums_i;
        st_d.vms = msr_vms_i;
        if (issue_valid && dec_hit) begin
            if (x_exc) begin
                st_d.exc_valid = 1'b1;
                st_d.ec        = x_ec;
                st_d.s         = 1'b1;
                if (x_diz) begin
                    st_d.diz = 1'b1;
                end
                st_d.ums = msr_um_i;
                st_d.vms = msr_vm_i;
                st_d.um  = 1'b0;
                st_d.vm  = 1'b0;
            end else begin
                st_d.wr_en = 1'b1;
                st_d.addr  = dec_addr;
                st_d.data  = lane_data;
                st_d.be    = lane_be;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    if (AREA_OPT) begin : g_area
        stage_t out_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_q <= '0;
            end else begin
                out_q <= st_q;
            end
        end
        assign out_s = out_q;
    end else begin : g_fast
        assign out_s = st_q;
    end

    assign wr_en_o     = out_s.wr_en;
    assign wr_addr_o   = out_s.addr;
    assign wr_data_o   = out_s.data;
    assign wr_be_o     = out_s.be;
    assign exc_valid_o = out_s.exc_valid;
    assign esr_ec_o    = out_s.ec;
    assign esr_s_o     = out_s.s;
    assign esr_diz_o   = out_s.diz;
    assign msr_um_o    = out_s.um;
    assign msr_vm_o    = out_s.vm;
    assign msr_ums_o   = out_s.ums;
    assign msr_vms_o   = out_s.vms;

    AST_WR_EXC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_o && exc_valid_o)); // R12
    AST_BE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> ($countones(wr_be_o) == 1)); // R5
    AST_DATA_REPL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (wr_data_o == {NBE{wr_data_o[7:0]}})); // R4
    AST_EXC_CLEARS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid_o |-> (!msr_um_o && !msr_vm_o && esr_s_o)); // R9
    AST_ESR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_valid_o |-> ($stable(esr_ec_o) && $stable(esr_s_o) && $stable(esr_diz_o))); // R11
    AST_EXC_NEEDS_VM: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.exc_valid |-> $past(msr_vm_i && issue_valid)); // R10
endmodule

// File: tb/sbyte_store_unit_tb.sv
module sbyte_store_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HIST       = 1024;

    typedef struct packed {
        logic        wr;
        logic [63:0] addr;
        logic [31:0] data;
        logic [3:0]  be;
        logic        exc;
        logic [4:0]  ec;
        logic        s;
        logic        diz;
        logic        um;
        logic        vm;
        logic        ums;
        logic        vms;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic issue_valid = 1'b0;
    logic [31:0] instr = '0, op_d = '0, op_a = '0, op_b = '0;
    logic um_i = 0, vm_i = 0, ums_i = 0, vms_i = 0, le_i = 0;
    logic miss_i = 0, noacc_i = 0, ro_i = 0;

    logic        wr0, exc0, s0, diz0, um0, vm0, ums0, vms0;
    logic [63:0] addr0;
    logic [31:0] data0;
    logic [3:0]  be0;
    logic [4:0]  ec0;
    logic        wr1, exc1, s1, diz1, um1, vm1, ums1, vms1;
    logic [63:0] addr1;
    logic [31:0] data1;
    logic [3:0]  be1;
    logic [4:0]  ec1;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    exp_t hist [HIST];
    logic [4:0] m_ec = '0;
    logic m_s = 1'b0, m_diz = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbyte_store_unit #(.AREA_OPT(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .instr(instr),
        .op_d(op_d), .op_a(op_a), .op_b(op_b),
        .msr_um_i(um_i), .msr_vm_i(vm_i), .msr_ums_i(ums_i), .msr_vms_i(vms_i),
        .msr_le_i(le_i), .tlb_miss_i(miss_i), .prot_noacc_i(noacc_i), .prot_ro_i(ro_i),
        .wr_en_o(wr0), .wr_addr_o(addr0), .wr_data_o(data0), .wr_be_o(be0),
        .exc_valid_o(exc0), .esr_ec_o(ec0), .esr_s_o(s0), .esr_diz_o(diz0),
        .msr_um_o(um0), .msr_vm_o(vm0), .msr_ums_o(ums0), .msr_vms_o(vms0)
    );

    sbyte_store_unit #(.AREA_OPT(1'b1)) u_dut_area (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .instr(instr),
        .op_d(op_d), .op_a(op_a), .op_b(op_b),
        .msr_um_i(um_i), .msr_vm_i(vm_i), .msr_ums_i(ums_i), .msr_vms_i(vms_i),
        .msr_le_i(le_i), .tlb_miss_i(miss_i), .prot_noacc_i(noacc_i), .prot_ro_i(ro_i),
        .wr_en_o(wr1), .wr_addr_o(addr1), .wr_data_o(data1), .wr_be_o(be1),
        .exc_valid_o(exc1), .esr_ec_o(ec1), .esr_s_o(s1), .esr_diz_o(diz1),
        .msr_um_o(um1), .msr_vm_o(vm1), .msr_ums_o(ums1), .msr_vms_o(vms1)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, expv, cyc);
        end
    endtask

    task automatic cmp(input exp_t e, input exp_t a, input string who);
        chk(a.wr == e.wr, "R1/R12", {who, " wr_en"}, 64'(a.wr), 64'(e.wr));
        chk(a.exc == e.exc, "R6/R7/R8/R10", {who, " exc_valid"}, 64'(a.exc), 64'(e.exc));
        if (e.wr) begin
            chk(a.addr == e.addr, "R2/R3", {who, " addr"}, a.addr, e.addr);
            chk(a.data == e.data, "R4", {who, " data"}, 64'(a.data), 64'(e.data));
            chk(a.be == e.be, "R5", {who, " be"}, 64'(a.be), 64'(e.be));
        end
        chk({a.ec, a.s} == {e.ec, e.s}, "R6/R7/R11", {who, " ec,s"}, 64'({a.ec, a.s}), 64'({e.ec, e.s}));
        chk(a.diz == e.diz, "R7/R11", {who, " diz"}, 64'(a.diz), 64'(e.diz));
        chk({a.um, a.vm, a.ums, a.vms} == {e.um, e.vm, e.ums, e.vms}, "R9", {who, " status"},
            64'({a.um, a.vm, a.ums, a.vms}), 64'({e.um, e.vm, e.ums, e.vms}));
    endtask

    function automatic exp_t act_fast();
        return '{wr0, addr0, data0, be0, exc0, ec0, s0, diz0, um0, vm0, ums0, vms0};
    endfunction

    function automatic exp_t act_area();
        return '{wr1, addr1, data1, be1, exc1, ec1, s1, diz1, um1, vm1, ums1, vms1};
    endfunction

    // model built from the requirements; updates the syndrome model
    task automatic model(output exp_t e);
        logic hit, rev, ext, little, tlb, prot;
        logic [1:0] off, lane;
        e = '0;
        e.um = um_i; e.vm = vm_i; e.ums = ums_i; e.vms = vms_i;
        hit  = issue_valid && (instr[31:26] == 6'b110100) && !instr[10] && !instr[8] && (instr[6:0] == 7'd0);
        rev  = instr[9];
        ext  = instr[7];
        tlb  = vm_i && miss_i;
        prot = vm_i && !miss_i && (ro_i || (noacc_i && um_i));
        if (hit && (tlb || prot)) begin
            e.exc = 1'b1;
            m_ec  = tlb ? 5'b10010 : 5'b10000;
            m_s   = 1'b1;
            if (prot) m_diz = 1'b1;
            e.ums = um_i; e.vms = vm_i; e.um = 1'b0; e.vm = 1'b0;
        end else if (hit) begin
            e.wr   = 1'b1;
            e.addr = ext ? {op_a, op_b} : {32'd0, op_a + op_b};
            off    = e.addr[1:0];
            little = le_i ^ rev;
            lane   = little ? off : 2'd3 - off;
            e.be   = 4'b0001 << lane;
            e.data = {4{op_d[7:0]}};
        end
        e.ec = m_ec; e.s = m_s; e.diz = m_diz;
    endtask

    function automatic logic [31:0] mk(input bit rev, input bit ext);
        logic [31:0] w;
        w = {6'b110100, 15'($urandom), 11'd0};
        w[9] = rev;
        w[7] = ext;
        return w;
    endfunction

    task automatic step(input bit iv, input logic [31:0] w, input logic [31:0] d,
                        input logic [31:0] a, input logic [31:0] b,
                        input bit um, input bit vm, input bit ums, input bit vms, input bit le,
                        input bit miss, input bit na, input bit ro);
        exp_t e;
        @(negedge clk);
        if (cyc >= 1) cmp(hist[(cyc-1) % HIST], act_fast(), "fast");
        if (cyc >= 2) cmp(hist[(cyc-2) % HIST], act_area(), "area");
        issue_valid = iv; instr = w; op_d = d; op_a = a; op_b = b;
        um_i = um; vm_i = vm; ums_i = ums; vms_i = vms; le_i = le;
        miss_i = miss; noacc_i = na; ro_i = ro;
        model(e);
        hist[cyc % HIST] = e;
        cyc++;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        // R11 reset state
        chk({wr0, exc0, ec0, s0, diz0, um0, vm0, ums0, vms0} == '0, "R11", "fast reset", 64'({wr0, exc0, ec0, s0, diz0}), 0);
        chk({wr1, exc1, ec1, s1, diz1, um1, vm1, ums1, vms1} == '0, "R11", "area reset", 64'({wr1, exc1, ec1, s1, diz1}), 0);
        rst_n = 1'b1;
        // R2 wrap-around sum, big-endian offset 1
        step(1, mk(0, 0), 32'h1234_56A5, 32'hFFFF_FFFE, 32'd3, 0, 0, 0, 0, 0, 0, 0, 0);
        // R3 extended address
        step(1, mk(0, 1), 32'h0000_003C, 32'hDEAD_BEEF, 32'h1234_5673, 1, 0, 1, 0, 0, 0, 0, 0);
        // R5 reversal turns big into little
        step(1, mk(1, 0), 32'h0000_0077, 32'h100, 32'h3, 0, 0, 0, 0, 0, 0, 0, 0);
        step(1, mk(1, 0), 32'h0000_0011, 32'h100, 32'h1, 0, 0, 0, 0, 1, 0, 0, 0);
        // R7 miss together with both violations: TLB wins (R6)
        step(1, mk(0, 0), 32'h55, 32'h40, 32'h0, 1, 1, 0, 0, 0, 1, 1, 1);
        // R8 no-access in supervisor mode is ignored
        step(1, mk(0, 0), 32'h66, 32'h41, 32'h0, 0, 1, 1, 1, 0, 0, 1, 0);
        // R7 no-access in user mode
        step(1, mk(0, 0), 32'h66, 32'h42, 32'h0, 1, 1, 0, 0, 0, 0, 1, 0);
        // R6 miss alone keeps diz
        step(1, mk(0, 1), 32'h99, 32'h43, 32'h0, 0, 1, 0, 0, 1, 1, 0, 0);
        // R10 virtual mode off ignores everything
        step(1, mk(1, 1), 32'hAB, 32'h44, 32'h7, 1, 0, 0, 1, 0, 1, 1, 1);
        // R1 reserved bit set and wrong opcode
        step(1, mk(0, 0) | 32'h0000_0400, 32'h12, 32'h45, 32'h0, 1, 1, 0, 0, 0, 1, 0, 0);
        step(1, {6'b110000, 26'd0}, 32'h12, 32'h45, 32'h0, 1, 1, 0, 0, 0, 0, 0, 1);
        step(0, mk(0, 0), 32'h12, 32'h45, 32'h0, 1, 1, 0, 0, 0, 1, 0, 0);
        for (int i = 0; i < 400; i++) begin
            logic [31:0] w;
            logic [2:0] r;
            w = mk(1'($urandom), 1'($urandom));
            r = 3'($urandom);
            if (r == 3'd0) w = w | (32'h1 << ($urandom % 11)) | 32'h0000_0001;
            if (r == 3'd1) w[31:26] = 6'($urandom);
            step(($urandom % 8) != 0, w, $urandom, $urandom, $urandom,
                 1'($urandom), ($urandom % 4) != 0, 1'($urandom), 1'($urandom), 1'($urandom),
                 ($urandom % 4) == 0, ($urandom % 3) == 0, ($urandom % 4) == 0);
        end
        repeat (3) step(0, 32'd0, 32'd0, 32'd0, 32'd0, 0, 0, 0, 0, 0, 0, 0, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule